// File: doc/BRIEF.md
# Dual-Modulus 32/33 Clock Prescaler

This block divides a fast clock by 32 or by 33, as chosen by a single mode input. The ratio is built from two parts. A small front cell divides by 2 or by 3. Four toggle stages follow it and count sixteen periods of that cell. A control term, formed from the stage outputs and the registered mode, moves the front cell into its divide-by-3 sequence for one of its sixteen periods. That one long period adds the extra input cycle.

The whole block runs on the input clock. Each toggle stage advances only when its clock enable is high, so no stage drives the clock of another. Two outputs are provided. One is a square-ish divided clock taken from the last stage. The other is a one-cycle tick that marks the last input cycle of each output period. A pulse-swallow counter or a phase detector can use either of them.

Top module: `pscl_dual_mod`

## Requirements
- R1: With the sampled mode at 1, consecutive `tick_o` pulses are exactly 32 input cycles apart, and `tick_o` is never high for two cycles in a row.
- R2: With the sampled mode at 0, consecutive `tick_o` pulses are exactly 33 input cycles apart.
- R3: The front cell has the states 00, 01 and 11, written as {first flop, second flop}. While its control is high it runs 00→01→00 (divide by 2) and its first flop does not change. While its control is low it runs 00→01→11→00 (divide by 3). If it is ever in state 10, the next state is 11.
- R4: The four toggle stages form a counter of front-cell periods that wraps from 15 to 0 on the `tick_o` cycle. The front-cell control is low only when all stages are 1 and the sampled mode is 0. A divide-by-33 period is therefore 15×2+3 cycles.
- R5: `clk_o` is the most significant stage. It is low for the first 16 input cycles of each output period and high for the rest: 16 cycles in divide-by-32 and 17 in divide-by-33.
- R6: `mode_i` is sampled only at the rising edge that ends a `tick_o` cycle. The sampled value sets the ratio of the period that begins there. Changes at any other time have no effect on any period length.
- R7: While `rst_n` is low, `tick_o` and `clk_o` are 0 and the sampled mode is 1. Reset is released through two synchronising flops, so the first `tick_o` is seen after the 33rd rising edge following the release. That first period always divides by 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 1 | Ratio select: 1 divides by 32, 0 divides by 33 |
| clk_o | output | 1 | Divided clock (most significant toggle stage) |
| tick_o | output | 1 | One-cycle pulse on the last input cycle of each output period |

## Verification
The properties assume that `mode_i` is synchronous to `clk` and settles well before each rising edge. They also assume that the front cell starts from its reset state, so the illegal state is reached only through a fault. The stimulus changes `mode_i` only at falling edges. In each period it holds one value for the first twenty cycles and then a second value up to the boundary edge, so a design that reads the raw input late in a period gives different period lengths from one that samples at the boundary. Reset is released on a falling edge, so the count of synchronising edges before the first tick is unambiguous.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

  // Front cell state: {first flop, second flop}
  typedef enum logic [1:0] {
    CS_00  = 2'b00,
    CS_01  = 2'b01,
    CS_BAD = 2'b10,
    CS_11  = 2'b11
  } cell_st_t;

  localparam int unsigned RSYNC_DEPTH = 2;

endpackage

// File: rtl/pscl_rst_sync.sv
module pscl_rst_sync #(
  parameter int unsigned DEPTH = pscl_pkg::RSYNC_DEPTH
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[DEPTH-1];

endmodule

// File: rtl/pscl_cell23.sv
module pscl_cell23
  import pscl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_i,   // 1: divide by 2, 0: divide by 3
  output logic end_o    // last input cycle of a cell period
);

  cell_st_t st_q;
  cell_st_t st_d;

  always_comb begin
    case (st_q)
      CS_00:   st_d = CS_01;
      CS_01:   st_d = ctl_i ? CS_00 : CS_11;
      CS_11:   st_d = CS_00;
      default: st_d = CS_11;  // recovery from the illegal code
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CS_00;
    end else begin
      st_q <= st_d;
    end
  end

  always_comb begin
    end_o = ((st_q == CS_01) && ctl_i) || (st_q == CS_11);
  end

  AST_CELL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i && (st_q != CS_11)) |=> $stable(st_q[1]))
    else $error("first flop moved while control high"); // R3

  AST_CELL_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_BAD) |=> (st_q == CS_11))
    else $error("illegal cell state not recovered"); // R3

  AST_CELL_DIV3_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == CS_01) && !ctl_i) |=> (st_q == CS_11))
    else $error("divide-by-3 step skipped"); // R3

endmodule

// File: rtl/pscl_tstage.sv
module pscl_tstage (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,   // advance this stage
  output logic q_o,
  output logic en_o    // carry: this stage falls 1 -> 0
);

  logic q_q;
  logic q_d;

  always_comb begin
    q_d = en_i ? ~q_q : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o  = q_q;
  assign en_o = en_i & q_q;

  AST_STAGE_ONLY_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(q_q))
    else $error("stage moved without enable"); // R4

endmodule

// File: rtl/pscl_dual_mod.sv
module pscl_dual_mod #(
  parameter int unsigned NSTAGE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  output logic clk_o,
  output logic tick_o
);

  localparam int unsigned CNT_W = NSTAGE;

  logic             srst_n;
  logic             cell_end;
  logic             cell_ctl;
  logic [NSTAGE:0]  carry;
  logic [CNT_W-1:0] sq;
  logic             mode_q;
  logic             mode_d;

  pscl_rst_sync u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pscl_cell23 u_cell (
    .clk   (clk),
    .rst_n (srst_n),
    .ctl_i (cell_ctl),
    .end_o (cell_end)
  );

  assign carry[0] = cell_end;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    pscl_tstage u_st (
      .clk   (clk),
      .rst_n (srst_n),
      .en_i  (carry[g]),
      .q_o   (sq[g]),
      .en_o  (carry[g+1])
    );
  end

  // OR of inverted stage outputs and the sampled mode
  always_comb begin
    cell_ctl = (|(~sq)) | mode_q;
  end

  always_comb begin
    mode_d = carry[NSTAGE] ? mode_i : mode_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_q <= 1'b1;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign tick_o = carry[NSTAGE];
  assign clk_o  = sq[CNT_W-1];

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!srst_n)
    tick_o |=> !tick_o)
    else $error("tick held for two cycles"); // R1

  AST_WRAP_AFTER_TICK: assert property (@(posedge clk) disable iff (!srst_n)
    tick_o |=> (sq == '0))
    else $error("stage counter did not wrap"); // R4

  AST_CLK_RISE_ON_END: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(clk_o) |-> $past(cell_end))
    else $error("divided clock rose outside a cell boundary"); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    !srst_n |-> (!tick_o && !clk_o))
    else $error("outputs active in reset"); // R7

endmodule

// File: tb/sim_pscl_dual_mod.sv
module sim_pscl_dual_mod;

  logic clk;
  logic rst_n;
  logic mode_i;
  logic clk_o;
  logic tick_o;

  int checks;
  int errors;
  int exp_q[$];
  bit released;
  bit done;

  pscl_dual_mod #(.NSTAGE(4)) u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .clk_o  (clk_o),
    .tick_o (tick_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: md for the body of a period, mb at the boundary edge (R6)
  task automatic run(input logic md, input logic mb);
    mode_i = md;
    repeat (20) @(negedge clk);
    mode_i = mb;
    do @(negedge clk); while (!tick_o);
    exp_q.push_back(mb ? 32 : 33);
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: period length and high time of clk_o
  initial begin
    int cnt;
    int hi;
    bit first;
    cnt = 0;
    hi = 0;
    first = 1'b1;
    wait (released);
    forever begin
      @(negedge clk);
      cnt++;
      if (clk_o) hi++;
      if (tick_o) begin
        if (first) begin
          chk("R7 first tick edge count", cnt, 33);
          chk("R5 R7 first period high time", hi, 16);
          first = 1'b0;
        end else if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          if (e == 32) chk("R1 R6 period length", cnt, e);
          else         chk("R2 R3 R4 R6 period length", cnt, e);
          chk("R5 clk_o high time", hi, e - 16);
        end
        cnt = 0;
        hi = 0;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    mode_i = 1'b0;
    released = 1'b0;
    done = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 tick in reset", int'(tick_o), 0);
    chk("R7 clk_o in reset", int'(clk_o), 0);
    rst_n = 1'b1;
    released = 1'b1;
    run(1'b1, 1'b0);
    run(1'b0, 1'b1);
    run(1'b0, 1'b1);
    run(1'b1, 1'b0);
    run(1'b1, 1'b0);
    run(1'b0, 1'b1);
    run(1'b1, 1'b1);
    run(1'b0, 1'b0);
    run(1'b0, 1'b1);
    run(1'b1, 1'b0);
    run(1'b1, 1'b1);
    run(1'b0, 1'b0);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule